// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer with Prescaler

This block is a 16-bit counter that serves four selectable functions from one shared count: a free-running software timer, a pulse-width modulator, an input-capture / output-compare unit and an external event counter. A single control register picks the mode, a power-of-two prescaler for the system-clock tick, and separate edge polarities for the two capture pins and the event pin. Software programs the block through one register write port. That port also loads the count directly and clears interrupt flags.

The operating mode is held in a four-state machine. The states are MODE_SOFT, MODE_PWM, MODE_CAPCMP and MODE_EVENT. Its only transition is a control-register write, which moves it from any state to the state named by the written mode field. Each state selects the count source: prescaled ticks in MODE_SOFT, MODE_PWM and MODE_CAPCMP, and synchronized pin edges in MODE_EVENT. Each state also decides which of the compare, capture and PWM functions are live.

A second two-state machine, PWM_LOW and PWM_HIGH, shapes the PWM output. It moves PWM_LOW→PWM_HIGH when the count wraps at the period value, and PWM_HIGH→PWM_LOW when the count matches the compare value. It is forced to PWM_LOW whenever the mode state is not MODE_PWM.

Top module: `tmr16_multimode`

## Requirements
- R1: While reset is asserted, count, both capture values, all four flags and pwm_out are 0. After reset the block runs as a software timer at divide 1, so count rises by one every clock.
- R2: Control bits [4:2] hold k, and count advances once every 2^k clocks (k=0 gives 1, k=7 gives 128). A control write restarts the divider and blocks advancing on its own edge, so the first advance lands 2^k clocks after the write edge.
- R3: A write to address 3 loads wr_data into count on that edge, and no advance takes place on that edge.
- R4: Control bits [1:0] select the mode: 00 software timer, 01 PWM, 10 capture/compare, 11 external event. pwm_out is 0 in every mode but 01.
- R5: In mode 11, count advances by one per selected edge of evt_pin, and prescaler ticks are ignored. Control bit 5 picks the edge (1 rising, 0 falling), and edges of the other polarity have no effect.
- R6: Each pin passes a two-flop synchronizer. A change set up before clock edge P1 acts on edge P3.
- R7: In mode 10, a selected edge on cap_pin[n] copies count into cap n's value and sets cap n's flag. Control bit 6 picks the edge for both pins (1 rising, 0 falling).
- R8: In modes 00, 01 and 11, capture pin edges leave capture values and capture flags unchanged.
- R9: In modes 01 and 10, count equal to the compare register (address 1) sets match_flag. In modes 00 and 11, match_flag is not set.
- R10: In mode 01, count returns to 0 after equalling the period register (address 2), so a period lasts period+1 ticks. pwm_out goes high on that wrap and low on the tick after count equals compare. At divide 1 this gives compare+1 high clocks per period.
- R11: An advance from all-ones to zero sets ovf_flag.
- R12: A write to address 4 clears each flag whose data bit is 1: bit 0 ovf, bit 1 match, bit 2 cap 0, bit 3 cap 1. Bits written 0 leave flags unchanged, and a set in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 control, 1 compare, 2 period, 3 count, 4 flag clear |
| wr_data | input | 16 | Write data |
| cap_pin | input | 2 | Asynchronous capture inputs |
| evt_pin | input | 1 | Asynchronous external event input |
| pwm_out | output | 1 | PWM waveform |
| count | output | 16 | Current count |
| cap0_value | output | 16 | Capture register of cap_pin[0] |
| cap1_value | output | 16 | Capture register of cap_pin[1] |
| ovf_flag | output | 1 | Overflow flag |
| match_flag | output | 1 | Compare match flag |
| cap0_flag | output | 1 | Capture flag of cap_pin[0] |
| cap1_flag | output | 1 | Capture flag of cap_pin[1] |

## Verification
The hardest situation to reach from the ports is a capture whose stored value can be predicted exactly. The count keeps moving while a pin edge crawls through three register stages. The bench first writes the control register with divide 128, which restarts the divider. It then loads a known count and toggles the pin. Far fewer than 128 clocks pass before the capture lands, so the count is frozen and the expected value is the loaded one. The PWM duty is checked the same way: the count is loaded to zero in PWM mode, the bench waits for the first rise, then counts high samples across one full period.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int unsigned CNT_W  = 16;
    localparam int unsigned PS_W   = 3;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned N_CAP  = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_CMP    = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_PERIOD = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_COUNT  = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_FLAGS  = 3'd4;

    typedef enum logic [1:0] {
        MODE_SOFT   = 2'b00,
        MODE_PWM    = 2'b01,
        MODE_CAPCMP = 2'b10,
        MODE_EVENT  = 2'b11
    } tmr_mode_e;

    typedef enum logic {
        PWM_LOW  = 1'b0,
        PWM_HIGH = 1'b1
    } pwm_state_e;

    // control register layout: [6] capture edge, [5] event edge, [4:2] prescale, [1:0] mode
    typedef struct packed {
        logic            cap_rise;
        logic            evt_rise;
        logic [PS_W-1:0] ps;
        tmr_mode_e       mode;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tmr16_sync_edge.sv
module tmr16_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic edge_hit
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;
    logic              level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign level    = sync_q[STAGES-1];
    assign edge_hit = rise_sel ? (level & ~last_q) : (~level & last_q);

endmodule

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler #(
    parameter int unsigned PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);

    localparam int unsigned DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] limit;
    logic             at_limit;

    always_comb begin
        span  = {{DIV_W{1'b0}}, 1'b1} << ps;
        limit = DIV_W'(span - 1'b1);
    end

    assign at_limit = (div_q == limit);
    assign tick     = at_limit && !restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart || at_limit) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr16_pwm_gen.sv
module tmr16_pwm_gen
    import tmr16_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable_next,
    input  logic wrap,
    input  logic duty_hit,
    output logic pwm_out
);

    pwm_state_e state_q;
    pwm_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PWM_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWM_LOW:  if (wrap) state_d = PWM_HIGH;
            PWM_HIGH: if (!wrap && duty_hit) state_d = PWM_LOW;
        endcase
        if (!enable_next) state_d = PWM_LOW;
    end

    always_comb begin
        unique case (state_q)
            PWM_LOW:  pwm_out = 1'b0;
            PWM_HIGH: pwm_out = 1'b1;
        endcase
    end

endmodule

// File: rtl/tmr16_multimode.sv
module tmr16_multimode
    import tmr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [N_CAP-1:0]  cap_pin,
    input  logic              evt_pin,
    output logic              pwm_out,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  cap0_value,
    output logic [CNT_W-1:0]  cap1_value,
    output logic              ovf_flag,
    output logic              match_flag,
    output logic              cap0_flag,
    output logic              cap1_flag
);

    localparam int unsigned SYNC_STAGES = 2;

    // register write decode
    logic ctrl_wr, cmp_wr, per_wr, cnt_wr, clr_wr;
    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    assign cmp_wr  = wr_en && (wr_addr == ADDR_CMP);
    assign per_wr  = wr_en && (wr_addr == ADDR_PERIOD);
    assign cnt_wr  = wr_en && (wr_addr == ADDR_COUNT);
    assign clr_wr  = wr_en && (wr_addr == ADDR_FLAGS);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            cmp_q    <= '0;
            period_q <= '0;
        end else begin
            if (ctrl_wr) ctrl_q   <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (cmp_wr)  cmp_q    <= wr_data;
            if (per_wr)  period_q <= wr_data;
        end
    end

    // mode state machine
    tmr_mode_e mode_q;
    tmr_mode_e mode_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_SOFT;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_comb begin
        mode_d = mode_q;
        if (ctrl_wr) begin
            unique case (wr_data[1:0])
                2'b00: mode_d = MODE_SOFT;
                2'b01: mode_d = MODE_PWM;
                2'b10: mode_d = MODE_CAPCMP;
                2'b11: mode_d = MODE_EVENT;
            endcase
        end
    end

    logic use_event, cmp_en, cap_en, pwm_en;

    always_comb begin
        unique case (mode_q)
            MODE_SOFT: begin
                use_event = 1'b0; cmp_en = 1'b0; cap_en = 1'b0; pwm_en = 1'b0;
            end
            MODE_PWM: begin
                use_event = 1'b0; cmp_en = 1'b1; cap_en = 1'b0; pwm_en = 1'b1;
            end
            MODE_CAPCMP: begin
                use_event = 1'b0; cmp_en = 1'b1; cap_en = 1'b1; pwm_en = 1'b0;
            end
            MODE_EVENT: begin
                use_event = 1'b1; cmp_en = 1'b0; cap_en = 1'b0; pwm_en = 1'b0;
            end
        endcase
    end

    // tick sources
    logic pre_tick;
    logic evt_edge;

    tmr16_prescaler #(.PS_W(PS_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctrl_wr),
        .ps      (ctrl_q.ps),
        .tick    (pre_tick)
    );

    tmr16_sync_edge #(.STAGES(SYNC_STAGES)) u_evt_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (evt_pin),
        .rise_sel (ctrl_q.evt_rise),
        .edge_hit (evt_edge)
    );

    logic [N_CAP-1:0] cap_edge;

    for (genvar i = 0; i < N_CAP; i++) begin : g_cap_sync
        tmr16_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (cap_pin[i]),
            .rise_sel (ctrl_q.cap_rise),
            .edge_hit (cap_edge[i])
        );
    end

    // counter
    logic step, step_eff, wrap_pwm, at_max;

    assign step     = use_event ? evt_edge : pre_tick;
    assign step_eff = step && !ctrl_wr && !cnt_wr;
    assign wrap_pwm = step_eff && pwm_en && (count_q == period_q);
    assign at_max   = (count_q == {CNT_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (cnt_wr) begin
            count_q <= wr_data;
        end else if (wrap_pwm) begin
            count_q <= '0;
        end else if (step_eff) begin
            count_q <= count_q + 1'b1;
        end
    end

    // capture registers
    logic [CNT_W-1:0] cap_q [N_CAP];
    logic [N_CAP-1:0] cap_set;

    for (genvar i = 0; i < N_CAP; i++) begin : g_cap_reg
        assign cap_set[i] = cap_en && cap_edge[i];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cap_q[i] <= '0;
            end else if (cap_set[i]) begin
                cap_q[i] <= count_q;
            end
        end
    end

    // flags: [0] overflow, [1] match, [2] cap 0, [3] cap 1
    localparam int unsigned N_FLAG = 2 + N_CAP;

    logic [N_FLAG-1:0] flag_q;
    logic [N_FLAG-1:0] flag_set;
    logic [N_FLAG-1:0] flag_clr;
    logic              match_set;

    assign match_set = cmp_en && (count_q == cmp_q);
    assign flag_set  = {cap_set, match_set, step_eff && at_max};
    assign flag_clr  = clr_wr ? wr_data[N_FLAG-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & ~flag_clr) | flag_set;
        end
    end

    // PWM output
    tmr16_pwm_gen u_pwm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_next (mode_d == MODE_PWM),
        .wrap        (wrap_pwm),
        .duty_hit    (count_q == cmp_q),
        .pwm_out     (pwm_out)
    );

    assign count      = count_q;
    assign cap0_value = cap_q[0];
    assign cap1_value = cap_q[1];
    assign ovf_flag   = flag_q[0];
    assign match_flag = flag_q[1];
    assign cap0_flag  = flag_q[2];
    assign cap1_flag  = flag_q[3];

endmodule

// File: rtl/tmr16_checker.sv
module tmr16_checker
    import tmr16_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       mode,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp,
    input logic             pwm_out,
    input logic             ovf_flag,
    input logic             match_flag,
    input logic             cap0_flag,
    input logic             cap1_flag
);

    // R3: without a write the count holds, steps by one or wraps to zero
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || (cnt == '0));

    // R11: overflow flag rises only as the count rolls from all-ones to zero
    a_r11_ovf_on_rollover: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(cnt) == {CNT_W{1'b1}}) && (cnt == '0));

    // R4: PWM output is only high in PWM mode
    a_r4_pwm_mode_only: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_out |-> (mode == 2'b01));

    // R9: match flag rises only after an equal compare in a compare mode
    a_r9_match_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag) |-> ($past(cnt) == $past(cmp)) &&
                              (($past(mode) == 2'b01) || ($past(mode) == 2'b10)));

    // R8: capture flags rise only in capture/compare mode
    a_r8_cap0_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap0_flag) |-> ($past(mode) == 2'b10));

    a_r8_cap1_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap1_flag) |-> ($past(mode) == 2'b10));

endmodule

bind tmr16_multimode tmr16_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .mode       (mode_q),
    .cnt        (count_q),
    .cmp        (cmp_q),
    .pwm_out    (pwm_out),
    .ovf_flag   (ovf_flag),
    .match_flag (match_flag),
    .cap0_flag  (cap0_flag),
    .cap1_flag  (cap1_flag)
);

// File: tb/tmr16_multimode_test.sv
module tmr16_multimode_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  cap_pin = '0;
    logic        evt_pin = 1'b0;
    logic        pwm_out;
    logic [15:0] count, cap0_value, cap1_value;
    logic        ovf_flag, match_flag, cap0_flag, cap1_flag;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    tmr16_multimode uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cap_pin(cap_pin), .evt_pin(evt_pin), .pwm_out(pwm_out), .count(count),
        .cap0_value(cap0_value), .cap1_value(cap1_value), .ovf_flag(ovf_flag),
        .match_flag(match_flag), .cap0_flag(cap0_flag), .cap1_flag(cap1_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        #12;
        chk("R1 count in reset", count, 0);
        chk("R1 flags in reset", {ovf_flag, match_flag, cap0_flag, cap1_flag, pwm_out}, 0);
        chk("R1 captures in reset", {cap0_value, cap1_value}, 0);
        @(negedge clk); rst_n = 1'b1;
        wait_n(2);
        begin
            logic [15:0] c0;
            c0 = count;
            wait_n(1);
            chk("R1 divide-1 after reset", count, c0 + 16'd1);
        end
    endtask

    task automatic t_prescale(input int k);
        int n;
        logic [15:0] c0;
        n = 1 << k;
        wr(3'd0, 16'(k << 2));
        c0 = count;
        if (n > 1) begin
            wait_n(n - 1);
            chk("R2 no advance before 2^k", count, c0);
            wait_n(1);
        end else begin
            wait_n(1);
        end
        chk("R2 first advance", count, c0 + 16'd1);
        wait_n(n);
        chk("R2 second advance", count, c0 + 16'd2);
    endtask

    task automatic t_load;
        wr(3'd0, 16'(7 << 2));
        wr(3'd3, 16'h1234);
        chk("R3 count load", count, 16'h1234);
    endtask

    task automatic pulse_evt;
        @(negedge clk); evt_pin = 1'b1;
        wait_n(4);
        evt_pin = 1'b0;
        wait_n(4);
    endtask

    task automatic t_event;
        wr(3'd0, 16'h0003 | 16'(1 << 5));
        wr(3'd3, 16'h0000);
        @(negedge clk); evt_pin = 1'b1;
        wait_n(2);
        chk("R6 no count two clocks after pin rise", count, 0);
        wait_n(1);
        chk("R6 count on third edge", count, 1);
        wait_n(2); evt_pin = 1'b0; wait_n(4);
        for (int i = 0; i < 4; i++) pulse_evt();
        chk("R5 rising edges counted", count, 5);
        wait_n(50);
        chk("R5 prescaler ignored in event mode", count, 5);
        wr(3'd0, 16'h0003);
        wr(3'd3, 16'h0000);
        @(negedge clk); evt_pin = 1'b1;
        wait_n(5);
        chk("R5 rising edge ignored when falling selected", count, 0);
        evt_pin = 1'b0;
        wait_n(5);
        pulse_evt(); pulse_evt();
        chk("R5 falling edges counted", count, 3);
    endtask

    task automatic t_capture;
        wr(3'd0, 16'h0002 | 16'(7 << 2) | 16'(1 << 6));
        wr(3'd1, 16'hF000);
        wr(3'd4, 16'h000F);
        wr(3'd3, 16'h0100);
        @(negedge clk); cap_pin[0] = 1'b1;
        wait_n(4);
        chk("R7 cap0 value", cap0_value, 16'h0100);
        chk("R7 cap flags after cap0", {cap0_flag, cap1_flag}, 2'b10);
        wr(3'd3, 16'h0222);
        @(negedge clk); cap_pin[1] = 1'b1;
        wait_n(4);
        chk("R7 cap1 value", cap1_value, 16'h0222);
        chk("R7 cap0 untouched by cap1", cap0_value, 16'h0100);
        wr(3'd0, 16'h0002 | 16'(7 << 2));
        wr(3'd3, 16'h0333);
        @(negedge clk); cap_pin[0] = 1'b0;
        wait_n(4);
        chk("R7 falling capture", cap0_value, 16'h0333);
    endtask

    task automatic t_cap_ignored;
        wr(3'd0, 16'(7 << 2));
        wr(3'd4, 16'h000F);
        @(negedge clk); cap_pin = 2'b01;
        wait_n(5);
        cap_pin = 2'b10;
        wait_n(5);
        cap_pin = 2'b00;
        wait_n(5);
        chk("R8 cap values kept outside mode 10", {cap0_value, cap1_value}, {16'h0333, 16'h0222});
        chk("R8 cap flags kept clear", {cap0_flag, cap1_flag}, 0);
    endtask

    task automatic t_match;
        wr(3'd0, 16'h0002);
        wr(3'd1, 16'h0050);
        wr(3'd3, 16'h0040);
        wr(3'd4, 16'h0002);
        chk("R12 match cleared", match_flag, 0);
        wait_n(30);
        chk("R9 match in mode 10", match_flag, 1);
        wr(3'd0, 16'h0000);
        wr(3'd3, 16'h0040);
        wr(3'd4, 16'h0002);
        wait_n(30);
        chk("R9 no match in mode 00", match_flag, 0);
    endtask

    task automatic t_ovf;
        wr(3'd0, 16'h0000);
        wr(3'd3, 16'hFFF0);
        wr(3'd4, 16'h000F);
        chk("R11 ovf clear before rollover", ovf_flag, 0);
        wait_n(20);
        chk("R11 ovf after rollover", ovf_flag, 1);
        wr(3'd4, 16'h000E);
        chk("R12 zero bit leaves ovf", ovf_flag, 1);
        wr(3'd4, 16'h0001);
        chk("R12 one bit clears ovf", ovf_flag, 0);
    endtask

    task automatic t_pwm;
        int highs;
        int guard;
        logic [15:0] maxc;
        wr(3'd0, 16'h0001);
        wr(3'd2, 16'd9);
        wr(3'd1, 16'd3);
        wr(3'd3, 16'd0);
        guard = 0;
        while (pwm_out !== 1'b1 && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        chk("R10 pwm rises", pwm_out, 1);
        highs = 0;
        maxc = 0;
        for (int i = 0; i < 10; i++) begin
            if (pwm_out) highs++;
            if (count > maxc) maxc = count;
            @(negedge clk);
        end
        chk("R10 high clocks per period", highs, 4);
        chk("R10 count never exceeds period", maxc, 9);
        chk("R9 match in mode 01", match_flag, 1);
        wr(3'd0, 16'h0000);
        highs = 0;
        for (int i = 0; i < 20; i++) begin
            if (pwm_out) highs++;
            @(negedge clk);
        end
        chk("R4 pwm low outside mode 01", highs, 0);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_prescale(0);
        t_prescale(3);
        t_prescale(7);
        t_load();
        t_event();
        t_capture();
        t_cap_ignored();
        t_match();
        t_ovf();
        t_pwm();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

endmodule